// File: doc/BRIEF.md
# Dual-Function Revision and Address-Load Register

This block is one byte-wide register on a small host I/O bus, decoded at a single port offset. It does one job for reads and another for writes. A read returns one of two bytes, picked by a control input. The first is a fixed identity byte: a chip-type nibble and a revision nibble. The second is a staged address byte kept inside the block.

While the enable control input is high, writes to the same port build a 16-bit address from two byte writes. The low byte comes first and the high byte second. On the cycle after the second write, the block issues a one-cycle load strobe with the full 16-bit value for a buffer counter outside the block.

The pairing is fragile on purpose. Any other host access between the two writes drops the pending low byte, so the next write starts a new pair. The host bus is made of plain strobes with no handshake. The counter-load output is a single-cycle valid with no ready: the consumer must take the value in the cycle the strobe is high, and no back-pressure is possible.

Top module: `revaddr_port`

## Requirements
- R1: After reset the staged byte is 0x22, the load strobe is low and the counter value output is 0x0000. An identity read with the jumper low returns 0x40.
- R2: While the show-staged input is 0, a read at offset 7 returns the chip-type nibble in bits 7:4 and the revision in bits 3:0. The chip type is 0100 with the jumper low and 0010 with the jumper high; the revision defaults to 0000. Read data is valid in the same cycle as the read strobe.
- R3: While the show-staged input is 1, a read at offset 7 returns the staged byte.
- R4: Read data is 0x00 in any cycle without a read strobe at offset 7.
- R5: A write at offset 7 while enable is low changes neither the staged byte nor the counter outputs, and raises no load strobe.
- R6: With enable high, a first write at offset 7 stores its byte as the staged byte. A following write at offset 7, even after idle cycles with no access, raises the load strobe for exactly one cycle, in the cycle after that write. During that cycle the counter value is {second byte, first byte}.
- R7: A read at any offset, or a write at any other offset, between the first and second write cancels the pending pair. The next write at offset 7 is then taken as a new low byte.
- R8: Enable low for a cycle between the two writes cancels the pending pair.
- R9: A write cycle in which the read strobe is also high is ignored, and it cancels any pending pair.
- R10: The counter value output holds the last loaded value between loads. The staged byte keeps its last low byte after a pair completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Host port offset |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Read strobe, one access per high cycle |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_rdata | output | 8 | Read data, combinational |
| show_staged | input | 1 | 1: reads return the staged byte; 0: the identity byte |
| load_enable | input | 1 | Enables two-write address loading |
| jumper_sel | input | 1 | Selects the chip-type code |
| cnt_load | output | 1 | One-cycle counter load strobe |
| cnt_value | output | 16 | Address to load into the buffer counter |

## Verification
A stuck or wrong phase flag shows at the ports in the next write at offset 7. That write either raises a load strobe that should not appear, or fails to raise one that should, and in both cases the counter value is wrong. A corrupted staged byte shows at once in a staged read, and in the low half of the next loaded value one cycle after the second write. An interruption that fails to clear the pairing is caught by the next two writes, which then load the wrong byte combination.

// File: rtl/revaddr_pkg.sv
package revaddr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] CHIP_CODE_LO = 4'b0100;
  localparam logic [3:0] CHIP_CODE_HI = 4'b0010;

  function automatic logic [BYTE_W-1:0] ident_byte(input logic jumper, input logic [3:0] rev);
    return {(jumper ? CHIP_CODE_HI : CHIP_CODE_LO), rev};
  endfunction
endpackage

// File: rtl/revaddr_decode.sv
module revaddr_decode #(
  parameter int ADDR_W   = 4,
  parameter int PORT_OFF = 7
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              load_enable,
  output logic              rd_hit,
  output logic              wr_accept,
  output logic              pair_abort
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(PORT_OFF);
  logic hit;

  always_comb begin
    hit        = (host_addr == OFF);
    rd_hit     = host_rd & hit;
    wr_accept  = host_wr & hit & load_enable & ~host_rd;
    pair_abort = host_rd | (host_wr & ~hit) | ~load_enable;
  end
endmodule

// File: rtl/revaddr_pair.sv
module revaddr_pair #(
  parameter int              BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] STAGE_RST = 8'h22,
  localparam int             CNT_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic              pair_abort,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] stage_q,
  output logic              load_q,
  output logic [CNT_W-1:0]  value_q
);
  logic pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      stage_q   <= STAGE_RST;
      load_q    <= 1'b0;
      value_q   <= '0;
    end else begin
      load_q <= 1'b0;
      if (pair_abort) begin
        pending_q <= 1'b0;
      end else if (wr_accept) begin
        if (!pending_q) begin
          stage_q   <= wdata;
          pending_q <= 1'b1;
        end else begin
          value_q   <= {wdata, stage_q};
          load_q    <= 1'b1;
          pending_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/revaddr_rdmux.sv
module revaddr_rdmux
  import revaddr_pkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h0
) (
  input  logic              rd_hit,
  input  logic              show_staged,
  input  logic              jumper_sel,
  input  logic [BYTE_W-1:0] stage_q,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    if (!rd_hit)          rdata = '0;
    else if (show_staged) rdata = stage_q;
    else                  rdata = ident_byte(jumper_sel, REV_ID);
  end
endmodule

// File: rtl/revaddr_port.sv
module revaddr_port
  import revaddr_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          PORT_OFF  = 7,
  parameter logic [3:0]  REV_ID    = 4'h0,
  parameter logic [7:0]  STAGE_RST = 8'h22,
  localparam int         CNT_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              show_staged,
  input  logic              load_enable,
  input  logic              jumper_sel,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_value
);
  logic              rd_hit, wr_accept, pair_abort;
  logic [BYTE_W-1:0] stage_q;

  revaddr_decode #(.ADDR_W(ADDR_W), .PORT_OFF(PORT_OFF)) u_dec (
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .load_enable(load_enable), .rd_hit(rd_hit), .wr_accept(wr_accept),
    .pair_abort(pair_abort)
  );

  revaddr_pair #(.BYTE_W(BYTE_W), .STAGE_RST(STAGE_RST)) u_pair (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .pair_abort(pair_abort),
    .wdata(host_wdata), .stage_q(stage_q), .load_q(cnt_load), .value_q(cnt_value)
  );

  revaddr_rdmux #(.REV_ID(REV_ID)) u_mux (
    .rd_hit(rd_hit), .show_staged(show_staged), .jumper_sel(jumper_sel),
    .stage_q(stage_q), .rdata(host_rdata)
  );
endmodule

// File: rtl/revaddr_port_chk.sv
module revaddr_port_chk #(
  parameter int         ADDR_W   = 4,
  parameter int         PORT_OFF = 7,
  parameter logic [3:0] REV_ID   = 4'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              host_rd,
  input logic              host_wr,
  input logic [7:0]        host_rdata,
  input logic              show_staged,
  input logic              load_enable,
  input logic              cnt_load,
  input logic [15:0]       cnt_value,
  input logic [7:0]        stage_q
);
  logic at_port;
  assign at_port = (host_addr == ADDR_W'(PORT_OFF));

  AST_REV_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && at_port && !show_staged) |-> (host_rdata[3:0] == REV_ID)); // R2
  AST_STAGED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && at_port && show_staged) |-> (host_rdata == stage_q)); // R3
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && at_port) |-> (host_rdata == 8'h00)); // R4
  AST_NO_LOAD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_enable |=> !cnt_load); // R5
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !cnt_load); // R6
  AST_LOAD_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_load) |-> (cnt_value[15:8] == $past(host_wdata))); // R6
  AST_NO_LOAD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !cnt_load); // R9
  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |-> $stable(cnt_value)); // R10
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && at_port && load_enable && !host_rd) |=> $stable(stage_q)); // R5
endmodule

bind revaddr_port revaddr_port_chk #(.ADDR_W(ADDR_W), .PORT_OFF(PORT_OFF), .REV_ID(REV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
  .show_staged(show_staged), .load_enable(load_enable), .cnt_load(cnt_load),
  .cnt_value(cnt_value), .stage_q(stage_q)
);

// File: tb/tb_revaddr_port.sv
module tb_revaddr_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_rdata;
  logic        show_staged = 1'b0, load_enable = 1'b0, jumper_sel = 1'b0;
  logic        cnt_load;
  logic [15:0] cnt_value;

  int n_checks = 0;
  int n_err = 0;
  logic [7:0]  m_stage;
  logic        m_pend;
  logic [15:0] m_value;

  always #(CLK_PERIOD/2) clk = ~clk;

  revaddr_port dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .show_staged(show_staged), .load_enable(load_enable), .jumper_sel(jumper_sel),
    .cnt_load(cnt_load), .cnt_value(cnt_value)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one bus cycle; model updated from the requirements, outputs checked after the edge
  task automatic cycle(input bit rd, input bit wr, input logic [3:0] a, input logic [7:0] d, input string req);
    bit exp_load;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
    exp_load = 1'b0;
    if (rd || (wr && a != 4'd7) || !load_enable) m_pend = 1'b0;
    else if (wr) begin
      if (!m_pend) begin m_stage = d; m_pend = 1'b1; end
      else begin m_value = {d, m_stage}; exp_load = 1'b1; m_pend = 1'b0; end
    end
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    chk(cnt_load == exp_load, req, {31'b0, cnt_load}, {31'b0, exp_load});
    chk(cnt_value == m_value, req, {16'b0, cnt_value}, {16'b0, m_value});
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1;
    chk(host_rdata == exp, req, {24'b0, host_rdata}, {24'b0, exp});
    m_pend = 1'b0;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    m_stage = 8'h22; m_pend = 1'b0; m_value = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cnt_load == 1'b0, "R1", {31'b0, cnt_load}, 0);
    chk(cnt_value == 16'h0, "R1", {16'b0, cnt_value}, 0);
    rst_n = 1'b1;
    rd_check(4'd7, 8'h40, "R1");
    show_staged = 1'b1;
    rd_check(4'd7, 8'h22, "R1");
    show_staged = 1'b0;

    // R2 identity for both jumper levels
    for (int j = 0; j < 2; j++) begin
      jumper_sel = j[0];
      rd_check(4'd7, (j == 0) ? 8'h40 : 8'h20, "R2");
    end
    jumper_sel = 1'b0;

    // R4 no strobe or other offsets read zero
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); host_addr = a[3:0]; host_rd = 1'b0; #1;
      chk(host_rdata == 8'h00, "R4", {24'b0, host_rdata}, 0);
      if (a != 7) rd_check(a[3:0], 8'h00, "R4");
    end

    // R5 writes ignored while disabled
    load_enable = 1'b0;
    cycle(1'b0, 1'b1, 4'd7, 8'h91, "R5");
    cycle(1'b0, 1'b1, 4'd7, 8'h92, "R5");
    show_staged = 1'b1;
    rd_check(4'd7, 8'h22, "R5");

    // R6 / R3 / R10 sweep of every low byte, high byte computed
    load_enable = 1'b1;
    for (int lo = 0; lo < 256; lo++) begin
      logic [7:0] hi;
      hi = 8'((lo * 7 + 3) ^ 8'h5a);
      cycle(1'b0, 1'b1, 4'd7, lo[7:0], "R6");
      if (lo % 16 == 0) cycle(1'b0, 1'b0, 4'd0, 8'h00, "R6");
      cycle(1'b0, 1'b1, 4'd7, hi, "R6");
      cycle(1'b0, 1'b0, 4'd0, 8'h00, "R10");
      rd_check(4'd7, lo[7:0], "R3");
    end

    // R7 interruption at every offset by write elsewhere and by read anywhere
    for (int off = 0; off < 16; off++) begin
      if (off != 7) begin
        cycle(1'b0, 1'b1, 4'd7, 8'hA0 + 8'(off), "R7");
        cycle(1'b0, 1'b1, off[3:0], 8'h33, "R7");
        cycle(1'b0, 1'b1, 4'd7, 8'hB0 + 8'(off), "R7");
        cycle(1'b0, 1'b1, 4'd7, 8'hC0 + 8'(off), "R7");
      end
      cycle(1'b0, 1'b1, 4'd7, 8'h10 + 8'(off), "R7");
      cycle(1'b1, 1'b0, off[3:0], 8'h00, "R7");
      cycle(1'b0, 1'b1, 4'd7, 8'h20 + 8'(off), "R7");
      cycle(1'b0, 1'b1, 4'd7, 8'h30 + 8'(off), "R7");
    end

    // R8 enable drop cancels pairing
    cycle(1'b0, 1'b1, 4'd7, 8'h5c, "R8");
    load_enable = 1'b0;
    cycle(1'b0, 1'b0, 4'd0, 8'h00, "R8");
    load_enable = 1'b1;
    cycle(1'b0, 1'b1, 4'd7, 8'h6d, "R8");
    cycle(1'b0, 1'b1, 4'd7, 8'h7e, "R8");

    // R9 write with simultaneous read ignored and aborts
    cycle(1'b0, 1'b1, 4'd7, 8'h11, "R9");
    cycle(1'b1, 1'b1, 4'd7, 8'h99, "R9");
    cycle(1'b0, 1'b1, 4'd7, 8'h44, "R9");
    cycle(1'b0, 1'b1, 4'd7, 8'h55, "R9");
    rd_check(4'd7, 8'h44, "R9");

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule